// File: doc/BRIEF.md
# Paired-Byte Data Stack Extension Unit

This unit is an execution slice attached to an 8-bit accumulator core. The core has an accumulator, two index registers and negative/zero flags. It runs five extra instructions that help code written for a 16-bit data stack. That stack sits in zero page, with index register X as its pointer. A 16-bit cell is carried in the register pair Y:A, with Y holding the high byte and A the low byte.

The core presents a decoded opcode, a start strobe and its current register values. The unit then does the following:
- It captures those operands.
- It runs any zero-page accesses through a single-port, synchronous-read memory. Read data arrives one cycle after the request.
- It returns updated A, X, Y, N and Z together with a one-cycle done pulse.

The five instructions are:
- a double increment of X, which drops one cell;
- a double decrement of X, which commits a pushed cell;
- a store of Y:A into the two bytes just below X;
- a load of Y:A from those two bytes;
- a 16-bit test of Y:A that sets the flags for a following conditional branch.

Top module: `stkx_unit`

## Requirements
- R1: While reset is asserted and afterwards until the first start, done and mem_req are 0 and a_out, x_out, y_out, n_out and z_out are all 0.
- R2: Opcode 0 (cell drop) sets x_out to (x_in + 2) mod 256. It leaves A, Y, N and Z as given and makes no memory request. done is high in the cycle after the start edge.
- R3: Opcode 1 (cell commit) sets x_out to (x_in - 2) mod 256. It is otherwise identical to R2.
- R4: Opcode 2 (pair store) issues two write requests in consecutive cycles, starting the cycle after the start edge. The first writes A to address (X - 2) mod 256 and the second writes Y to (X - 1) mod 256. done follows in the next cycle, three cycles after start, and no register or flag changes.
- R5: Opcode 3 (pair load) issues two read requests in consecutive cycles, first at (X - 2) mod 256 and then at (X - 1) mod 256. The first returned byte goes to A and the second to Y. done is high four cycles after start, and X, N and Z are unchanged.
- R6: Opcode 4 (pair test) leaves A, X and Y unchanged. It sets Z to 1 exactly when Y:A is 0x0000 and sets N to bit 7 of Y. It completes like R2.
- R7: Opcodes 5, 6 and 7 complete like R2 with every output value equal to its input and no memory request.
- R8: A start, or any change of opcode or operand inputs, while an instruction is in flight is ignored. The running sequence, its addresses and its results are unaffected.
- R9: done is a single-cycle pulse, mem_req is never high together with done, and no memory request occurs outside the access cycles of opcodes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, taken only when idle |
| opcode | input | 3 | Extension opcode, 0..4 defined |
| a_in | input | 8 | Accumulator from the core (low byte of the pair) |
| x_in | input | 8 | Stack index from the core |
| y_in | input | 8 | Y register from the core (high byte of the pair) |
| n_in | input | 1 | Negative flag from the core |
| z_in | input | 1 | Zero flag from the core |
| mem_rdata | input | 8 | Zero-page read data, valid the cycle after a read request |
| done | output | 1 | One-cycle completion pulse |
| a_out | output | 8 | Resulting accumulator |
| x_out | output | 8 | Resulting stack index |
| y_out | output | 8 | Resulting Y register |
| n_out | output | 1 | Resulting negative flag |
| z_out | output | 1 | Resulting zero flag |
| mem_req | output | 1 | Zero-page access request |
| mem_we | output | 1 | Write enable for the request |
| mem_addr | output | 8 | Zero-page address |
| mem_wdata | output | 8 | Write data |

## Verification
The hardest case to reach is a pair access whose second byte wraps past the top of zero page. With X equal to 1, the low byte lands at 0xFF and the high byte at 0x00. With X equal to 0, both bytes sit at 0xFE and 0xFF. The stimulus sets X to those values before both the store and the load, then reads the cells back with different values loaded into A and Y first. A second hard case is a start arriving in mid-sequence. The driver raises start again with a different opcode and a scrambled index during the first access cycle. The scoreboard then still expects the original addresses, the original data and the original results.

// File: rtl/stkx_pkg.sv
package stkx_pkg;

  parameter int unsigned BYTE_W   = 8;
  parameter int unsigned ZP_AW    = 8;
  parameter int unsigned OPC_W    = 3;
  parameter int unsigned CELL_LEN = 2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ZP_AW-1:0]  zaddr_t;
  typedef logic [OPC_W-1:0]  opc_t;

  localparam opc_t OPC_DROP = opc_t'(0);
  localparam opc_t OPC_COMMIT = opc_t'(1);
  localparam opc_t OPC_PUT  = opc_t'(2);
  localparam opc_t OPC_GET  = opc_t'(3);
  localparam opc_t OPC_TEST = opc_t'(4);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC0,
    ST_ACC1,
    ST_CAP,
    ST_FIN
  } state_t;

  typedef struct packed {
    byte_t  a;
    zaddr_t x;
    byte_t  y;
    logic   n;
    logic   z;
  } regs_t;

  function automatic zaddr_t idx_up(zaddr_t x);
    return x + zaddr_t'(CELL_LEN);
  endfunction

  function automatic zaddr_t idx_dn(zaddr_t x);
    return x - zaddr_t'(CELL_LEN);
  endfunction

  function automatic zaddr_t pair_addr(zaddr_t x, logic hi);
    return x - zaddr_t'(CELL_LEN) + zaddr_t'(hi);
  endfunction

  function automatic logic pair_zero(byte_t lo, byte_t hi);
    return (lo == '0) && (hi == '0);
  endfunction

  function automatic logic pair_neg(byte_t hi);
    return hi[BYTE_W-1];
  endfunction

  function automatic logic op_uses_mem(opc_t op);
    return (op == OPC_PUT) || (op == OPC_GET);
  endfunction

  function automatic regs_t launch(opc_t op, regs_t cur);
    regs_t r;
    r = cur;
    case (op)
      OPC_DROP:   r.x = idx_up(cur.x);
      OPC_COMMIT: r.x = idx_dn(cur.x);
      OPC_TEST: begin
        r.z = pair_zero(cur.a, cur.y);
        r.n = pair_neg(cur.y);
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/stkx_seq.sv
module stkx_seq
  import stkx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  opc_t opcode,
  output opc_t op_q,
  output logic accept,
  output logic done,
  output logic acc_lo,
  output logic acc_hi,
  output logic cap_lo,
  output logic cap_hi
);

  state_t state;
  state_t nxt;
  logic   busy;
  logic   is_get;

  assign busy   = (state != ST_IDLE);
  assign accept = start && !busy;
  assign done   = (state == ST_FIN);
  assign acc_lo = (state == ST_ACC0);
  assign acc_hi = (state == ST_ACC1);
  assign is_get = (op_q == OPC_GET);
  assign cap_lo = acc_hi && is_get;
  assign cap_hi = (state == ST_CAP);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (accept) nxt = op_uses_mem(opcode) ? ST_ACC0 : ST_FIN;
      ST_ACC0: nxt = ST_ACC1;
      ST_ACC1: nxt = is_get ? ST_CAP : ST_FIN;
      ST_CAP:  nxt = ST_FIN;
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= '0;
    end else begin
      state <= nxt;
      if (accept) op_q <= opcode;
    end
  end

  // done lasts exactly one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // the latched opcode cannot be replaced mid-flight
  assert_op_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q));

  // second access immediately follows the first
  assert_hi_after_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hi |-> $past(acc_lo));

  // a store finishes right after its second access
  assert_put_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OPC_PUT) |-> $past(acc_hi));

endmodule

// File: rtl/stkx_regs.sv
module stkx_regs
  import stkx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  opc_t  opcode,
  input  opc_t  op_q,
  input  logic  done,
  input  logic  cap_lo,
  input  logic  cap_hi,
  input  byte_t mem_rdata,
  input  regs_t cur,
  output regs_t res
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res <= '0;
    end else if (accept) begin
      res <= launch(opcode, cur);
    end else if (cap_lo) begin
      res.a <= mem_rdata;
    end else if (cap_hi) begin
      res.y <= mem_rdata;
    end
  end

  assert_drop_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OPC_DROP) |-> res.x == zaddr_t'($past(cur.x) + zaddr_t'(2)));

  assert_commit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OPC_COMMIT) |-> res.x == zaddr_t'($past(cur.x) - zaddr_t'(2)));

  assert_get_keeps_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hi |-> $stable(res.x) && $stable(res.n) && $stable(res.z));

  assert_test_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OPC_TEST) |->
      (res.z == ((res.a == '0) && (res.y == '0))) && (res.n == res.y[BYTE_W-1]));

  assert_ignored_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q > OPC_TEST) |-> res == $past(cur));

endmodule

// File: rtl/stkx_mport.sv
module stkx_mport
  import stkx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   acc_lo,
  input  logic   acc_hi,
  input  opc_t   op_q,
  input  regs_t  res,
  output logic   mem_req,
  output logic   mem_we,
  output zaddr_t mem_addr,
  output byte_t  mem_wdata
);

  assign mem_req   = acc_lo || acc_hi;
  assign mem_we    = mem_req && (op_q == OPC_PUT);
  assign mem_addr  = pair_addr(res.x, acc_hi);
  assign mem_wdata = acc_hi ? res.y : res.a;

  // high byte address is the low byte address plus one, wrapping in zero page
  assert_pair_adjacent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hi |-> mem_addr == zaddr_t'($past(mem_addr) + zaddr_t'(1)));

endmodule

// File: rtl/stkx_unit.sv
module stkx_unit
  import stkx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [BYTE_W-1:0] a_in,
  input  logic [ZP_AW-1:0]  x_in,
  input  logic [BYTE_W-1:0] y_in,
  input  logic              n_in,
  input  logic              z_in,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic [BYTE_W-1:0] a_out,
  output logic [ZP_AW-1:0]  x_out,
  output logic [BYTE_W-1:0] y_out,
  output logic              n_out,
  output logic              z_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ZP_AW-1:0]  mem_addr,
  output logic [BYTE_W-1:0] mem_wdata
);

  opc_t  op_q;
  logic  accept;
  logic  acc_lo;
  logic  acc_hi;
  logic  cap_lo;
  logic  cap_hi;
  regs_t cur;
  regs_t res;

  assign cur.a = a_in;
  assign cur.x = x_in;
  assign cur.y = y_in;
  assign cur.n = n_in;
  assign cur.z = z_in;

  stkx_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .opcode (opcode),
    .op_q   (op_q),
    .accept (accept),
    .done   (done),
    .acc_lo (acc_lo),
    .acc_hi (acc_hi),
    .cap_lo (cap_lo),
    .cap_hi (cap_hi)
  );

  stkx_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .opcode    (opcode),
    .op_q      (op_q),
    .done      (done),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .mem_rdata (mem_rdata),
    .cur       (cur),
    .res       (res)
  );

  stkx_mport u_mport (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_lo    (acc_lo),
    .acc_hi    (acc_hi),
    .op_q      (op_q),
    .res       (res),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign a_out = res.a;
  assign x_out = res.x;
  assign y_out = res.y;
  assign n_out = res.n;
  assign z_out = res.z;

  assert_req_not_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !done);

  // writes only come from the store opcode
  assert_write_only_put_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req && (op_q == OPC_PUT));

endmodule

// File: tb/stkx_unit_bench.sv
`timescale 1ns/1ps
module stkx_unit_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, start, n_in, z_in;
  logic [2:0] opcode;
  logic [7:0] a_in, x_in, y_in, mem_rdata;
  logic       done, n_out, z_out, mem_req, mem_we;
  logic [7:0] a_out, x_out, y_out, mem_addr, mem_wdata;

  stkx_unit u_stkx_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .a_in(a_in), .x_in(x_in), .y_in(y_in), .n_in(n_in), .z_in(z_in),
    .mem_rdata(mem_rdata), .done(done), .a_out(a_out), .x_out(x_out),
    .y_out(y_out), .n_out(n_out), .z_out(z_out), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // single-port zero page, synchronous read
  logic [7:0] zp [0:255];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) zp[mem_addr] <= mem_wdata;
      mem_rdata <= zp[mem_addr];
    end
  end

  // reference state
  logic [7:0] r_a, r_x, r_y;
  logic       r_n, r_z;
  logic [7:0] ref_zp [0:255];

  typedef struct { logic [7:0] a, x, y; logic n, z; string tag; } res_t;
  typedef struct { logic we; logic [7:0] addr, data; string tag; } acc_t;
  res_t res_q[$];
  acc_t acc_q[$];

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // monitor: compares memory traffic and results against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        if (acc_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9 unexpected request act=%0h exp=none", mem_addr);
        end else begin
          acc_t m;
          m = acc_q.pop_front();
          check({m.tag, " we"}, 32'(mem_we), 32'(m.we));
          check({m.tag, " addr"}, 32'(mem_addr), 32'(m.addr));
          if (m.we) check({m.tag, " wdata"}, 32'(mem_wdata), 32'(m.data));
        end
      end
      if (done) begin
        if (res_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9 unexpected done act=1 exp=0");
        end else begin
          res_t e;
          e = res_q.pop_front();
          check({e.tag, " a"}, 32'(a_out), 32'(e.a));
          check({e.tag, " x"}, 32'(x_out), 32'(e.x));
          check({e.tag, " y"}, 32'(y_out), 32'(e.y));
          check({e.tag, " nz"}, 32'({n_out, z_out}), 32'({e.n, e.z}));
        end
      end
    end
  end

  task automatic set_regs(input logic [7:0] a, x, y, input logic n, z);
    r_a = a; r_x = x; r_y = y; r_n = n; r_z = z;
  endtask

  // driver: computes the expectation, queues it, then launches the opcode
  task automatic run_op(input logic [2:0] op, input bit noisy, input string tag);
    res_t e;
    acc_t m;
    int lat, want;
    logic [7:0] lo_ad, hi_ad;
    lo_ad = r_x - 8'd2;
    hi_ad = r_x - 8'd1;
    e.a = r_a; e.x = r_x; e.y = r_y; e.n = r_n; e.z = r_z; e.tag = tag;
    want = 1;
    case (op)
      3'd0: e.x = r_x + 8'd2;
      3'd1: e.x = r_x - 8'd2;
      3'd2: begin
        want = 3;
        m.we = 1'b1; m.addr = lo_ad; m.data = r_a; m.tag = tag; acc_q.push_back(m);
        m.addr = hi_ad; m.data = r_y; acc_q.push_back(m);
        ref_zp[lo_ad] = r_a;
        ref_zp[hi_ad] = r_y;
      end
      3'd3: begin
        want = 4;
        m.we = 1'b0; m.addr = lo_ad; m.data = 8'h00; m.tag = tag; acc_q.push_back(m);
        m.addr = hi_ad; acc_q.push_back(m);
        e.a = ref_zp[lo_ad];
        e.y = ref_zp[hi_ad];
      end
      3'd4: begin
        e.z = (r_a == 8'h00) && (r_y == 8'h00);
        e.n = r_y[7];
      end
      default: ;
    endcase
    res_q.push_back(e);
    a_in = r_a; x_in = r_x; y_in = r_y; n_in = r_n; z_in = r_z;
    opcode = op; start = 1'b1;
    @(negedge clk);
    lat = 1;
    if (noisy && !done) begin
      start = 1'b1; opcode = 3'd0; x_in = 8'hA5; a_in = 8'h3C; y_in = 8'hC3;
    end else begin
      start = 1'b0;
    end
    while (!done && lat < 20) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    start = 1'b0;
    check({tag, " latency"}, 32'(lat), 32'(want));
    r_a = e.a; r_x = e.x; r_y = e.y; r_n = e.n; r_z = e.z;
    @(negedge clk);
    check({tag, " R9 done pulse"}, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      zp[i] = 8'(i) ^ 8'h5A;
      ref_zp[i] = 8'(i) ^ 8'h5A;
    end
    rst_n = 1'b0; start = 1'b0; opcode = 3'd0;
    a_in = 8'h00; x_in = 8'h00; y_in = 8'h00; n_in = 1'b0; z_in = 1'b0;
    set_regs(8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 reset done", 32'(done), 32'd0);
    check("R1 reset req", 32'(mem_req), 32'd0);
    check("R1 reset regs", 32'({a_out, x_out, y_out, n_out, z_out}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'({done, mem_req}), 32'd0);

    // R2 / R3: double steps with wrap, flags preserved
    set_regs(8'h11, 8'h10, 8'h22, 1'b1, 1'b0);
    run_op(3'd0, 1'b0, "R2 drop mid");
    set_regs(8'h11, 8'hFF, 8'h22, 1'b0, 1'b1);
    run_op(3'd0, 1'b0, "R2 drop wrap FF");
    set_regs(8'h33, 8'hFE, 8'h44, 1'b1, 1'b1);
    run_op(3'd0, 1'b0, "R2 drop wrap FE");
    set_regs(8'h33, 8'h00, 8'h44, 1'b1, 1'b0);
    run_op(3'd1, 1'b0, "R3 commit wrap 00");
    set_regs(8'h33, 8'h01, 8'h44, 1'b0, 1'b1);
    run_op(3'd1, 1'b0, "R3 commit wrap 01");

    // R4 / R5: push then pop round trip at X=0x40
    set_regs(8'h34, 8'h40, 8'h12, 1'b0, 1'b0);
    run_op(3'd2, 1'b0, "R4 store mid");
    run_op(3'd1, 1'b0, "R3 commit after store");
    r_a = 8'hEE; r_y = 8'hDD;
    run_op(3'd0, 1'b0, "R2 drop before load");
    run_op(3'd3, 1'b0, "R5 load round trip");
    check("R5 round trip A", 32'(r_a), 32'h34);
    check("R5 round trip Y", 32'(r_y), 32'h12);

    // wrap of the pair address at X=0 and X=1
    set_regs(8'hA1, 8'h00, 8'hB2, 1'b1, 1'b0);
    run_op(3'd2, 1'b0, "R4 store X=00");
    set_regs(8'hC3, 8'h01, 8'hD4, 1'b0, 1'b1);
    run_op(3'd2, 1'b0, "R4 store X=01");
    set_regs(8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
    run_op(3'd3, 1'b0, "R5 load X=00");
    set_regs(8'h00, 8'h01, 8'h00, 1'b0, 1'b0);
    run_op(3'd3, 1'b0, "R5 load X=01");
    set_regs(8'h00, 8'hFF, 8'h00, 1'b0, 1'b0);
    run_op(3'd3, 1'b0, "R5 load X=FF");

    // R6: pair test over the corner values
    set_regs(8'h00, 8'h20, 8'h00, 1'b1, 1'b0);
    run_op(3'd4, 1'b0, "R6 test 0000");
    set_regs(8'h80, 8'h20, 8'h00, 1'b1, 1'b1);
    run_op(3'd4, 1'b0, "R6 test 0080");
    set_regs(8'h00, 8'h20, 8'h80, 1'b0, 1'b1);
    run_op(3'd4, 1'b0, "R6 test 8000");
    set_regs(8'hFF, 8'h20, 8'h00, 1'b1, 1'b1);
    run_op(3'd4, 1'b0, "R6 test 00FF");

    // R7: undefined opcodes change nothing
    set_regs(8'h5E, 8'h77, 8'hE5, 1'b1, 1'b0);
    run_op(3'd5, 1'b0, "R7 opcode 5");
    set_regs(8'h01, 8'h02, 8'h03, 1'b0, 1'b1);
    run_op(3'd6, 1'b0, "R7 opcode 6");
    run_op(3'd7, 1'b0, "R7 opcode 7");

    // R8: restart attempts during a store and a load
    set_regs(8'h9A, 8'h80, 8'h78, 1'b0, 1'b0);
    run_op(3'd2, 1'b1, "R8 busy store");
    r_a = 8'h00; r_y = 8'h00;
    run_op(3'd3, 1'b1, "R8 busy load");
    check("R8 load after busy A", 32'(r_a), 32'h9A);
    check("R8 load after busy Y", 32'(r_y), 32'h78);

    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", 32'(res_q.size() + acc_q.size()), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule